// File: doc/BRIEF.md
# Interrupt request input conditioner

This block sits between two active-low external interrupt pins and the CPU core. It turns the pin levels into two request lines. The first pin is a maskable request. Software picks whether it fires on a low level or on a falling edge. The second pin is a nonmaskable request that only responds to a low level. Because it is level sensitive, any number of open-drain sources can pull it low together on one shared line.

Both pins pass through a two-flop synchronizer before any decision is made. The synchronized levels can always be read back. The block also holds the CPU's two interrupt mask bits. Reset sets both of them. The maskable one can be set and cleared by CPU strobes. The nonmaskable one can only be cleared, and only a reset sets it again. A small write port holds the trigger-mode bit and the pin pull-up enable. Vector selection and priority between requests belong to the CPU and are not part of this block.

Top module: `irq_cond`

## Requirements
- R1: While reset is asserted, and right after it is released, `imask_o` and `xmask_o` are 1, `edge_mode_o` is 0 (level mode), `pullup_en_o` is 1, and both request outputs are 0.
- R2: `pin_lvl_o` shows the maskable pin on bit 0 and the nonmaskable pin on bit 1. A pin change appears there after two rising clock edges, not after one. It is readable whatever the mask and mode settings are.
- R3: In level mode, `irq_req_o` is 1 exactly while the synchronized maskable pin is low and `imask_o` is 0.
- R4: `imask_set_i` sets `imask_o` and `imask_clr_i` clears it on the next edge. When both are pulsed in the same cycle, the set wins. While `imask_o` is 1, `irq_req_o` stays 0.
- R5: Writing 1 to bit 0 at address 0 selects edge mode. In edge mode, a falling edge on the synchronized maskable pin sets a pending latch. It shows on `irq_req_o` three clock edges after the pin falls. The latch also captures an edge while masked, and the request appears as soon as the mask is cleared.
- R6: `irq_ack_i` clears the pending latch. A pin held low does not set it again. A falling edge in the same cycle as the acknowledge leaves the latch set.
- R7: Writing 0 to bit 0 at address 0 returns to level mode and clears the pending latch. Re-entering edge mode does not bring back the old request.
- R8: `nmi_req_o` is 1 exactly while the synchronized nonmaskable pin is low and `xmask_o` is 0.
- R9: `xmask_clr_i` clears `xmask_o`. No other input except reset sets it again. Register writes and the maskable-mask strobes leave it at 0.
- R10: Bit 0 at address 1 drives `pullup_en_o`. Writing to address 1 does not change the trigger mode, and writing to address 0 does not change the pull-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| irq_pin_ni | input | 1 | Maskable interrupt pin, active low, asynchronous |
| nmi_pin_ni | input | 1 | Nonmaskable interrupt pin, active low, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register address: 0 mode, 1 pull-up |
| cfg_wdata_i | input | DATA_W | Register write data, bit 0 used |
| imask_set_i | input | 1 | CPU strobe: set maskable mask |
| imask_clr_i | input | 1 | CPU strobe: clear maskable mask |
| xmask_clr_i | input | 1 | CPU strobe: clear nonmaskable mask (one-way) |
| irq_ack_i | input | 1 | CPU acknowledge of the maskable request |
| irq_req_o | output | 1 | Maskable request to the CPU |
| nmi_req_o | output | 1 | Nonmaskable request to the CPU |
| imask_o | output | 1 | Maskable mask bit |
| xmask_o | output | 1 | Nonmaskable mask bit |
| edge_mode_o | output | 1 | 1 = falling-edge trigger, 0 = low-level trigger |
| pullup_en_o | output | 1 | Pull-up enable for both pins |
| pin_lvl_o | output | 2 | Synchronized pin levels (bit 0 maskable, bit 1 nonmaskable) |

## Verification
The bench holds the maskable pin low across an acknowledge. A design that re-arms on level would raise the request again. It pulses the acknowledge in the same cycle that a new edge is detected. A design that lets the clear win would lose that interrupt. It also leaves a stale pending edge, leaves edge mode and re-enters it. A design that keeps the latch would present a phantom request. It tries every path that could set the nonmaskable mask again after software cleared it. A leaky design would silently block the nonmaskable input. Sampling the readback one edge early catches a synchronizer that is too short.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    // Register addresses and the bit used inside each register
    localparam int unsigned REG_MODE = 0;
    localparam int unsigned REG_PULL = 1;
    localparam int unsigned MODE_BIT = 0;
    localparam int unsigned PULL_BIT = 0;

    // Maskable path state
    typedef struct packed {
        logic imask;  // mask bit, 1 = blocked
        logic pend;   // edge-mode pending latch
        logic prev;   // last synchronized pin level
    } mpath_st_t;

    // Configuration registers
    typedef struct packed {
        logic edge_mode;
        logic pull_en;
    } cfg_st_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Pins idle high, so the chain resets to all ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_mask_path.sv
module irq_mask_path
    import irq_cond_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_lvl_i,
    input  logic edge_mode_i,
    input  logic imask_set_i,
    input  logic imask_clr_i,
    input  logic ack_i,
    output logic req_o,
    output logic imask_o
);

    mpath_st_t st_d, st_q;
    logic      fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev & ~pin_lvl_i;
        st_d.prev = pin_lvl_i;

        // set strobe has priority over clear
        if (imask_set_i) begin
            st_d.imask = 1'b1;
        end else if (imask_clr_i) begin
            st_d.imask = 1'b0;
        end

        // a new edge beats an acknowledge; level mode flushes the latch
        if (!edge_mode_i) begin
            st_d.pend = 1'b0;
        end else if (fall) begin
            st_d.pend = 1'b1;
        end else if (ack_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{imask: 1'b1, pend: 1'b0, prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = ~st_q.imask & (edge_mode_i ? st_q.pend : ~pin_lvl_i);
    assign imask_o = st_q.imask;

    // R4
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        imask_set_i |=> imask_o);

    // R5
    edge_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && st_q.prev && !pin_lvl_i) |=> st_q.pend);

    // R6
    ack_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !(st_q.prev && !pin_lvl_i)) |=> !st_q.pend);

    // R7
    level_drops_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(edge_mode_i) |=> !st_q.pend);

endmodule

// File: rtl/irq_nmi_path.sv
module irq_nmi_path (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_lvl_i,
    input  logic xmask_clr_i,
    output logic req_o,
    output logic xmask_o
);

    logic xmask_d, xmask_q;

    // one-way: only reset can set the mask
    always_comb begin
        xmask_d = xmask_q;
        if (xmask_clr_i) begin
            xmask_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            xmask_q <= 1'b1;
        end else begin
            xmask_q <= xmask_d;
        end
    end

    assign req_o   = ~xmask_q & ~pin_lvl_i;
    assign xmask_o = xmask_q;

    // R9
    xmask_one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$rose(xmask_q));

endmodule

// File: rtl/irq_cond.sv
module irq_cond
    import irq_cond_pkg::*;
#(
    parameter int unsigned ADDR_W      = 1,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              irq_pin_ni,
    input  logic              nmi_pin_ni,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              imask_set_i,
    input  logic              imask_clr_i,
    input  logic              xmask_clr_i,
    input  logic              irq_ack_i,
    output logic              irq_req_o,
    output logic              nmi_req_o,
    output logic              imask_o,
    output logic              xmask_o,
    output logic              edge_mode_o,
    output logic              pullup_en_o,
    output logic [1:0]        pin_lvl_o
);

    localparam int unsigned NPINS = 2;

    logic [NPINS-1:0] pin_sync;
    cfg_st_t          cfg_d, cfg_q;
    logic             wr_mode, wr_pull;
    logic             unused_wdata;

    assign unused_wdata = ^cfg_wdata_i;

    irq_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({nmi_pin_ni, irq_pin_ni}),
        .sync_o  (pin_sync)
    );

    assign wr_mode = cfg_we_i && (cfg_addr_i == ADDR_W'(REG_MODE));
    assign wr_pull = cfg_we_i && (cfg_addr_i == ADDR_W'(REG_PULL));

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mode) begin
            cfg_d.edge_mode = cfg_wdata_i[MODE_BIT];
        end
        if (wr_pull) begin
            cfg_d.pull_en = cfg_wdata_i[PULL_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{edge_mode: 1'b0, pull_en: 1'b1};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    irq_mask_path i_mask (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_lvl_i   (pin_sync[0]),
        .edge_mode_i (cfg_q.edge_mode),
        .imask_set_i (imask_set_i),
        .imask_clr_i (imask_clr_i),
        .ack_i       (irq_ack_i),
        .req_o       (irq_req_o),
        .imask_o     (imask_o)
    );

    irq_nmi_path i_nmi (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_lvl_i   (pin_sync[1]),
        .xmask_clr_i (xmask_clr_i),
        .req_o       (nmi_req_o),
        .xmask_o     (xmask_o)
    );

    assign edge_mode_o = cfg_q.edge_mode;
    assign pullup_en_o = cfg_q.pull_en;
    assign pin_lvl_o   = pin_sync;

    // R10
    pull_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_pull |=> (pullup_en_o == $past(cfg_wdata_i[PULL_BIT])));

    // R10
    mode_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !wr_mode) |=> $stable(edge_mode_o));

endmodule

// File: tb/test_irq_cond.sv
module test_irq_cond;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       irq_pin, nmi_pin;
    logic       we;
    logic [0:0] addr;
    logic [7:0] wdata;
    logic       iset, iclr, xclr, ack;
    logic       irq_req, nmi_req, imask, xmask, edge_mode, pull_en;
    logic [1:0] lvl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // {irq_pin, nmi_pin, exp_irq, exp_nmi, exp_lvl[1:0]}
    localparam logic [5:0] LVL_VEC [6] = '{
        6'b11_00_11,
        6'b01_10_10,
        6'b10_01_01,
        6'b00_11_00,
        6'b01_10_10,
        6'b11_00_11
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cond i_irq_cond (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_pin_ni  (irq_pin),
        .nmi_pin_ni  (nmi_pin),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .imask_set_i (iset),
        .imask_clr_i (iclr),
        .xmask_clr_i (xclr),
        .irq_ack_i   (ack),
        .irq_req_o   (irq_req),
        .nmi_req_o   (nmi_req),
        .imask_o     (imask),
        .xmask_o     (xmask),
        .edge_mode_o (edge_mode),
        .pullup_en_o (pull_en),
        .pin_lvl_o   (lvl)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [0:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick(1);
        we = 1'b0; wdata = 8'h00;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_lvl;
        rst_n = 1'b0; irq_pin = 1'b1; nmi_pin = 1'b1;
        we = 1'b0; addr = '0; wdata = '0;
        iset = 1'b0; iclr = 1'b0; xclr = 1'b0; ack = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 imask", imask, 1);
        chk("R1 xmask", xmask, 1);
        chk("R1 mode", edge_mode, 0);
        chk("R1 pullup", pull_en, 1);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 nmi_req", nmi_req, 0);

        // masks hold requests off; readback still works
        irq_pin = 1'b0; nmi_pin = 1'b0;
        tick(3);
        chk("R4 masked irq", irq_req, 0);
        chk("R8 masked nmi", nmi_req, 0);
        chk("R2 readback while masked", lvl, 2'b00);
        irq_pin = 1'b1; nmi_pin = 1'b1;
        tick(3);

        iclr = 1'b1; xclr = 1'b1; tick(1); iclr = 1'b0; xclr = 1'b0;
        chk("R4 imask cleared", imask, 0);
        chk("R9 xmask cleared", xmask, 0);

        // level-mode vector table (R2, R3, R8)
        prev_lvl = 2'b11;
        for (int i = 0; i < 6; i++) begin
            irq_pin = LVL_VEC[i][5];
            nmi_pin = LVL_VEC[i][4];
            tick(1);
            chk("R2 one edge not yet", lvl, prev_lvl);
            tick(1);
            chk("R2 readback", lvl, LVL_VEC[i][1:0]);
            chk("R3 level irq", irq_req, LVL_VEC[i][3]);
            chk("R8 level nmi", nmi_req, LVL_VEC[i][2]);
            prev_lvl = LVL_VEC[i][1:0];
        end

        // R4 set and clear together: set wins
        irq_pin = 1'b0; tick(3);
        iset = 1'b1; iclr = 1'b1; tick(1); iset = 1'b0; iclr = 1'b0;
        chk("R4 set wins", imask, 1);
        chk("R4 irq blocked", irq_req, 0);
        iclr = 1'b1; tick(1); iclr = 1'b0;
        chk("R3 unmasked level", irq_req, 1);
        irq_pin = 1'b1; tick(3);

        // R9 nothing but reset re-sets xmask
        iset = 1'b1; tick(1); iset = 1'b0;
        iclr = 1'b1; tick(1); iclr = 1'b0;
        wr(1'b0, 8'hFF); wr(1'b0, 8'h00); wr(1'b1, 8'h01);
        pulse_ack();
        nmi_pin = 1'b0; tick(3);
        chk("R9 xmask stays clear", xmask, 0);
        chk("R9 nmi passes", nmi_req, 1);
        nmi_pin = 1'b1; tick(3);

        // R5 edge mode
        wr(1'b0, 8'h01);
        chk("R5 mode set", edge_mode, 1);
        irq_pin = 1'b0; tick(2);
        chk("R5 not before third edge", irq_req, 0);
        tick(1);
        chk("R5 edge request", irq_req, 1);

        // R6 ack, pin held low: no re-trigger
        pulse_ack();
        chk("R6 ack clears", irq_req, 0);
        tick(3);
        chk("R6 held low no retrigger", irq_req, 0);

        // R5 edge captured while masked
        irq_pin = 1'b1; tick(3);
        iset = 1'b1; tick(1); iset = 1'b0;
        irq_pin = 1'b0; tick(3);
        chk("R5 masked edge hidden", irq_req, 0);
        iclr = 1'b1; tick(1); iclr = 1'b0;
        chk("R5 masked edge kept", irq_req, 1);

        // R6 ack in the same cycle as a new edge
        pulse_ack();
        irq_pin = 1'b1; tick(3);
        irq_pin = 1'b0; tick(2);
        pulse_ack();
        chk("R6 edge beats ack", irq_req, 1);

        // R7 leaving edge mode flushes the latch
        irq_pin = 1'b1; tick(3);
        chk("R7 pending held", irq_req, 1);
        wr(1'b0, 8'h00);
        tick(1);
        chk("R7 level mode pin high", irq_req, 0);
        wr(1'b0, 8'h01);
        tick(1);
        chk("R7 no stale request", irq_req, 0);
        chk("R7 mode back to edge", edge_mode, 1);

        // R10 pull-up control
        wr(1'b1, 8'hFE);
        chk("R10 pullup off", pull_en, 0);
        chk("R10 mode untouched", edge_mode, 1);
        wr(1'b0, 8'h01);
        chk("R10 pullup untouched", pull_en, 0);

        // R1 reset in the middle of operation
        rst_n = 1'b0; tick(1);
        chk("R1 pullup in reset", pull_en, 1);
        chk("R1 xmask in reset", xmask, 1);
        chk("R1 imask in reset", imask, 1);
        chk("R1 mode in reset", edge_mode, 0);
        rst_n = 1'b1; tick(2);
        chk("R1 pullup after reset", pull_en, 1);
        chk("R9 reset re-sets xmask", xmask, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule